// File: doc/BRIEF.md
# Programmable Multi-Source Frequency Generator Bank

This block holds six frequency generators that all run in one fast system clock domain. The source clocks arrive as single-cycle tick inputs. Each generator picks one of these sources, can be switched off, and counts a programmable number of source ticks per output period. Each generator drives two outputs: a square-wave level and a one-cycle tick-enable that marks the end of each output period. Downstream logic in the same clock domain uses these as clock enables.

Two 32-bit control registers, written over a plain register bus, configure the bank. Each register carries a 10-bit field for each of three generators. A build parameter selects the field layout. The legacy layout has one source-select bit and a separate enable bit. The extended layout has a three-way source code in which code zero means off, plus a per-register scale bit that switches the divider from even steps to unit steps. A new divider or source setting takes effect at the next period boundary, so no short output period is ever produced.

Top module: `fgen_bank`

## Requirements
- R1: Both control registers reset to zero. A register returns on `rd_data` all 32 bits last written to it, whether or not the bits are used, and it changes only when `wr_en` is high with `wr_sel` pointing at it.
- R2: Generator k uses register k/3, in bits [10*(k%3)+9 : 10*(k%3)]. Inside a field, bits [9:2] hold the divider code n.
- R3: Legacy layout: field bit 1 enables the generator, field bit 0 selects source 0 or source 1, and one output period lasts (n+1)*2 ticks of the selected source.
- R4: Extended layout: field bits [1:0] equal to 0 switch the generator off. The values 1, 2 and 3 select sources 0, 1 and 2.
- R5: Extended layout: when bit 30 of a register is set, its three generators divide by n+1. When bit 30 is clear, they divide by (n+1)*2.
- R6: An off generator holds `gen_clk` and `gen_tick` low and clears its count. After the write that enables it, counting starts on the second clock edge, and the first `gen_tick` follows exactly D counted source ticks (D is the divisor).
- R7: A change of divider code or source made during a period leaves that period at its old length. The new setting governs the period that follows.
- R8: `gen_tick` is high for one clock, in the cycle after the source tick that completes a period. With D = 1 it follows every tick of the selected source with a latency of one clock.
- R9: Within each period, `gen_clk` stays low for the first floor(D/2) counted source ticks and is high for the rest.
- R10: In the legacy layout, bit 30 has no effect on the divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register selected for a write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Register selected for readback |
| rd_data | output | 32 | Readback of the selected register |
| src_tick | input | 3 | One-cycle tick of each source clock |
| gen_clk | output | 6 | Divided square-wave level, one bit per generator |
| gen_tick | output | 6 | Period-end tick-enable, one bit per generator |

## Verification
The assertions assume that each source tick lasts one clock and that control writes are ordinary synchronous strobes. The bench keeps to this by building the source ticks from a free-running cycle count: source 0 ticks every cycle, source 1 every second cycle and source 2 every third cycle. It drives all inputs half a cycle away from the active edge. Period lengths are compared only after several periods of a settled configuration. The one exception is the period that follows a source switch, whose length depends on the phase of the new source; that period is marked as unchecked.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

   // Divide span for a divider code: unit steps when unit_step is set,
   // otherwise even steps.
   function automatic logic [15:0] fgen_span(input logic [15:0] code,
                                             input logic unit_step);
      logic [15:0] base;
      base = code + 16'd1;
      return unit_step ? base : (base << 1);
   endfunction

endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
   parameter int NUM_REG = 2,
   parameter int REG_W   = 32,
   localparam int SEL_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [REG_W-1:0]         wr_data,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [REG_W-1:0]         rd_data,
   output logic [NUM_REG*REG_W-1:0] ctrl_flat
);
   logic [REG_W-1:0] reg_q [NUM_REG];

   for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            reg_q[r] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(r)))
            reg_q[r] <= wr_data;
      end
      assign ctrl_flat[r*REG_W +: REG_W] = reg_q[r];
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NUM_REG; r++)
         if (rd_sel == SEL_W'(r))
            rd_data = reg_q[r];
   end
endmodule

// File: rtl/fgen_decode.sv
module fgen_decode
   import fgen_pkg::*;
#(
   parameter bit EXTENDED = 1'b1,
   parameter int FIELD_W  = 10,
   parameter int DIV_W    = 8,
   parameter int SRC_W    = 2,
   localparam int DVW     = DIV_W + 2
) (
   input  logic [FIELD_W-1:0] field,
   input  logic               scale,
   output logic               en,
   output logic [SRC_W-1:0]   src,
   output logic [DVW-1:0]     divisor
);
   logic [DIV_W-1:0] code;
   assign code    = field[DIV_W+1:2];
   assign divisor = DVW'(fgen_span(16'(code), scale));

   if (EXTENDED) begin : g_ext
      // code 0 of the source pair is the off state
      assign en  = |field[1:0];
      assign src = SRC_W'(field[1:0] - 2'd1);
   end else begin : g_leg
      assign en  = field[1];
      assign src = SRC_W'(field[0]);
   end
endmodule

// File: rtl/fgen_divider.sv
module fgen_divider #(
   parameter int DVW     = 10,
   parameter int SRC_W   = 2,
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_en,
   input  logic [SRC_W-1:0]   cfg_src,
   input  logic [DVW-1:0]     cfg_div,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               sel_tick,
   output logic               gen_clk,
   output logic               gen_tick
);
   logic [DVW-1:0]   cnt_q;
   logic [DVW-1:0]   div_q;
   logic [SRC_W-1:0] src_q;
   logic             run_q;
   logic             tick_q;
   logic             last;

   always_comb begin
      sel_tick = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
         if (src_q == SRC_W'(s))
            sel_tick = src_tick[s];
   end

   assign last = (cnt_q == (div_q - DVW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         div_q  <= DVW'(1);
         src_q  <= '0;
         run_q  <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         run_q  <= cfg_en;
         tick_q <= 1'b0;
         if (!(cfg_en && run_q)) begin
            // idle or first enabled cycle: hold count, track settings
            cnt_q <= '0;
            div_q <= cfg_div;
            src_q <= cfg_src;
         end else if (sel_tick) begin
            if (last) begin
               cnt_q  <= '0;
               div_q  <= cfg_div;
               src_q  <= cfg_src;
               tick_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + DVW'(1);
            end
         end
      end
   end

   assign gen_tick = tick_q;
   assign gen_clk  = run_q && (cnt_q >= (div_q >> 1));
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank #(
   parameter bit EXTENDED    = 1'b1,
   parameter int NUM_REG     = 2,
   parameter int GEN_PER_REG = 3,
   parameter int REG_W       = 32,
   parameter int FIELD_W     = 10,
   parameter int DIV_W       = 8,
   parameter int SCALE_POS   = 30,
   parameter int NUM_SRC     = 3,
   localparam int NUM_GEN    = NUM_REG * GEN_PER_REG,
   localparam int SEL_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
   localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int DVW        = DIV_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [REG_W-1:0]   rd_data,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic [NUM_GEN-1:0] gen_clk,
   output logic [NUM_GEN-1:0] gen_tick
);
   if (FIELD_W * GEN_PER_REG > SCALE_POS) begin : g_bad_fields
      $error("fgen_bank: fields overlap the scale bit");
   end
   if (SCALE_POS >= REG_W) begin : g_bad_scale
      $error("fgen_bank: scale bit outside register");
   end
   if (DIV_W + 2 > FIELD_W) begin : g_bad_div
      $error("fgen_bank: divider code does not fit the field");
   end
   if (NUM_SRC < (EXTENDED ? 3 : 2)) begin : g_bad_src
      $error("fgen_bank: too few sources for the chosen layout");
   end

   logic [NUM_REG*REG_W-1:0] ctrl_flat;
   logic [NUM_GEN-1:0]       gen_en;
   logic [NUM_GEN-1:0]       sel_tick;
   logic                     unused_ctrl;

   assign unused_ctrl = ^ctrl_flat;

   fgen_regs #(.NUM_REG(NUM_REG), .REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .ctrl_flat(ctrl_flat)
   );

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      localparam int REG_BASE = (g / GEN_PER_REG) * REG_W;
      localparam int FLD_BASE = REG_BASE + (g % GEN_PER_REG) * FIELD_W;

      logic             scale;
      logic [SRC_W-1:0] cfg_src;
      logic [DVW-1:0]   cfg_div;

      if (EXTENDED) begin : g_scale
         assign scale = ctrl_flat[REG_BASE + SCALE_POS];
      end else begin : g_noscale
         assign scale = 1'b0;
      end

      fgen_decode #(
         .EXTENDED(EXTENDED), .FIELD_W(FIELD_W),
         .DIV_W(DIV_W), .SRC_W(SRC_W)
      ) u_dec (
         .field  (ctrl_flat[FLD_BASE +: FIELD_W]),
         .scale  (scale),
         .en     (gen_en[g]),
         .src    (cfg_src),
         .divisor(cfg_div)
      );

      fgen_divider #(.DVW(DVW), .SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_en  (gen_en[g]),
         .cfg_src (cfg_src),
         .cfg_div (cfg_div),
         .src_tick(src_tick),
         .sel_tick(sel_tick[g]),
         .gen_clk (gen_clk[g]),
         .gen_tick(gen_tick[g])
      );
   end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
   parameter int NUM_GEN = 6,
   parameter int NUM_REG = 2,
   parameter int REG_W   = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [NUM_REG*REG_W-1:0] ctrl_flat,
   input logic [NUM_GEN-1:0]       gen_en,
   input logic [NUM_GEN-1:0]       sel_tick,
   input logic [NUM_GEN-1:0]       gen_clk,
   input logic [NUM_GEN-1:0]       gen_tick
);
   // R1
   ctrl_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl_flat == '0));

   // R1
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_flat));

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
      // R6
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !gen_en[g] |=> (!gen_tick[g] && !gen_clk[g]));

      // R8
      tick_after_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gen_tick[g] |-> $past(sel_tick[g]));

      // R8
      tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gen_tick[g] |-> $past(gen_en[g]));
   end
endmodule

bind fgen_bank fgen_bank_chk #(
   .NUM_GEN(NUM_GEN), .NUM_REG(NUM_REG), .REG_W(REG_W)
) u_chk (.*);

// File: tb/test_fgen_bank.sv
module test_fgen_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [0:0]  rd_sel = '0;
   logic [31:0] rd_ext, rd_leg;
   logic [2:0]  src_tick = '0;
   logic [5:0]  gclk_e, gtick_e, gclk_l, gtick_l;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;
   logic [31:0] shadow [2];
   int last_t [2][6];

   typedef struct {
      int    inst;
      int    gen;
      int    iv;
      string tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #2 clk = ~clk;

   fgen_bank #(.EXTENDED(1'b1)) i_fgen_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_ext),
      .src_tick(src_tick), .gen_clk(gclk_e), .gen_tick(gtick_e)
   );

   fgen_bank #(.EXTENDED(1'b0)) i_fgen_bank_leg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_leg),
      .src_tick(src_tick), .gen_clk(gclk_l), .gen_tick(gtick_l)
   );

   // source 0 every cycle, source 1 every 2nd, source 2 every 3rd
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) src_tick <= {(cyc % 3) == 0, (cyc % 2) == 0, 1'b1};

   function automatic logic tk(int k, int g);
      return (k == 0) ? gtick_e[g] : gtick_l[g];
   endfunction

   function automatic logic lv(int k, int g);
      return (k == 0) ? gclk_e[g] : gclk_l[g];
   endfunction

   function automatic logic [9:0] fx(int n, logic [1:0] low);
      return {8'(n), low};
   endfunction

   function automatic logic [31:0] put(logic [31:0] base, int slot, logic [9:0] f);
      logic [31:0] m;
      m = 32'h3FF << (10 * slot);
      return (base & ~m) | ({22'd0, f} << (10 * slot));
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares the interval of the front expected item
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            for (int g = 0; g < 6; g++) begin
               if (tk(k, g)) begin
                  if (sb_q.size() > 0 && sb_q[0].inst == k && sb_q[0].gen == g
                      && last_t[k][g] >= 0) begin
                     if (sb_q[0].iv >= 0)
                        check(sb_q[0].tag, cyc - last_t[k][g], sb_q[0].iv);
                     void'(sb_q.pop_front());
                  end
                  last_t[k][g] = cyc;
               end
            end
         end
      end
   end

   task automatic wr(int r, logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = 1'(r);
      wr_data = d;
      shadow[r] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(int r, string tag);
      @(negedge clk);
      rd_sel = 1'(r);
      #1;
      check32({tag, " ext"}, rd_ext, shadow[r]);
      check32({tag, " leg"}, rd_leg, shadow[r]);
   endtask

   task automatic push(int k, int g, int iv, string tag);
      sb_item_t it;
      it.inst = k; it.gen = g; it.iv = iv; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic settle(int k, int g, string tag);
      int seen = 0;
      int w = 0;
      while (seen < 3 && w < 3000) begin
         @(negedge clk);
         w++;
         if (tk(k, g)) seen++;
      end
      if (seen < 3) check({tag, " no ticks"}, seen, 3);
   endtask

   task automatic drain(string tag);
      int w = 0;
      while (sb_q.size() > 0 && w < 4000) begin
         @(negedge clk);
         w++;
      end
      if (sb_q.size() > 0) begin
         check({tag, " pending"}, sb_q.size(), 0);
         sb_q.delete();
      end
   endtask

   task automatic steady(int k, int g, int iv, string tag);
      settle(k, g, tag);
      push(k, g, iv, tag);
      push(k, g, iv, tag);
      drain(tag);
   endtask

   task automatic quiet(int k, int g, int n, string tag);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tk(k, g) || lv(k, g)) hits++;
      end
      check(tag, hits, 0);
   endtask

   task automatic sync_tick(int k, int g);
      int w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!tk(k, g) && w < 3000);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int hits;
      int k;
      logic [31:0] r1;
      for (int a = 0; a < 2; a++)
         for (int g = 0; g < 6; g++) last_t[a][g] = -1;
      shadow[0] = '0;
      shadow[1] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of registers and outputs
      rd_chk(0, "R1 reset reg0");
      rd_chk(1, "R1 reset reg1");
      hits = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if ((gclk_e | gtick_e | gclk_l | gtick_l) != 0) hits++;
      end
      check("R6 reset outputs low", hits, 0);

      // R1: full-width readback, unused bits included
      wr(0, 32'hDEAD_BEEF);
      wr(1, 32'hC123_4567);
      rd_chk(0, "R1 readback reg0");
      rd_chk(1, "R1 readback reg1");
      wr(0, 32'h0);
      wr(1, 32'h0);
      rd_chk(0, "R1 cleared reg0");

      // R2 R3 R4: one write, read by both layouts
      r1 = put(put(32'h0, 0, fx(1, 2'b10)), 1, fx(2, 2'b11));
      wr(0, r1);
      steady(1, 0, 4,  "R3 leg gen0 src0 div4");
      steady(1, 1, 12, "R3 leg gen1 src1 div6");
      steady(0, 0, 8,  "R4 ext gen0 src1 div4");
      steady(0, 1, 18, "R2 ext gen1 src2 div6");
      quiet(0, 2, 30, "R4 ext gen2 off");

      // R5 R8 R10: scale bit set in register 1
      r1 = 32'h4000_0000;
      r1 = put(r1, 0, fx(4, 2'b01));
      r1 = put(r1, 1, fx(0, 2'b11));
      r1 = put(r1, 2, fx(7, 2'b10));
      wr(1, r1);
      steady(0, 3, 5,  "R5 ext gen3 unit div5");
      steady(0, 4, 3,  "R8 ext gen4 div1 follows src2");
      steady(0, 5, 16, "R5 ext gen5 unit div8");
      steady(1, 4, 4,  "R10 leg gen4 div2");
      steady(1, 5, 16, "R10 leg gen5 div16");
      quiet(1, 3, 40, "R3 leg gen3 enable bit clear");

      // R9: duty of a divide-by-5 period, src0
      sync_tick(0, 3);
      hits = 0;
      if (gclk_e[3]) hits++;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (gclk_e[3]) hits++;
      end
      check("R9 ext gen3 high cycles div5", hits, 3);

      // R5: scale bit cleared
      wr(1, r1 & ~32'h4000_0000);
      steady(0, 3, 10, "R5 ext gen3 even div10");

      // R4 R6: source code 0 switches off
      wr(1, put(shadow[1], 0, fx(4, 2'b00)));
      quiet(0, 3, 40, "R6 ext gen3 off");

      // R6: first tick after re-enable, div6 src0
      wr(1, put(shadow[1], 0, fx(2, 2'b01)));
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!gtick_e[3] && k < 100);
      check("R6 ext gen3 first period after enable", k, 7);
      steady(0, 3, 6, "R6 ext gen3 div6");

      // R7: divider change mid-period
      sync_tick(0, 3);
      @(negedge clk);
      push(0, 3, 6, "R7 ext gen3 old period kept");
      push(0, 3, 12, "R7 ext gen3 new period");
      wr(1, put(shadow[1], 0, fx(5, 2'b01)));
      drain("R7 ext div change");

      // R7: legacy source change mid-period
      sync_tick(1, 0);
      @(negedge clk);
      push(1, 0, 4, "R7 leg gen0 old source kept");
      push(1, 0, -1, "R7 leg gen0 phase period");
      push(1, 0, 8, "R7 leg gen0 new source");
      wr(0, put(shadow[0], 0, fx(1, 2'b11)));
      drain("R7 leg src change");

      // R3 R6: legacy enable bit cleared
      wr(0, put(shadow[0], 0, fx(1, 2'b01)));
      quiet(1, 0, 40, "R6 leg gen0 disabled");

      repeat (5) @(negedge clk);
      summary();
   end
endmodule